// File: doc/BRIEF.md
# Push-Pull PWM Pulse Steering Core

This block is the digital heart of a fixed-frequency, two-phase switching controller. A free-running period counter takes the place of an analog sawtooth. Each period opens with a programmable blanking interval that acts as dead time. A compare value then marks the count at which the pulse ends. Each valid pulse is steered to one of two outputs, `out_a` or `out_b`, in strict alternation, so each output switches at half the period rate. This suits a push-pull or half-bridge stage.

Two small pieces of state make the steering safe. A metering latch allows one pulse per period: once a pulse has ended, for any reason, nothing more is emitted until the next period. A steering memory records which output fired last, so the following pulse always goes to the other one. This holds even across periods that produced no pulse at all.

The current-limit trip, the active-low shutdown and the undervoltage lockout act combinationally, so a pulse is cut in the same cycle a fault appears. An external sync pulse restarts the period so that several cores can share one timebase. The pins are plain control signals. Nothing flows as a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pwm_pp_core`

## Requirements
- R1: While `rst_n` is low, both outputs are low. Reset clears the period counter, the metering latch and the steering memory, so the first pulse after reset appears on `out_a`.
- R2: Without sync, the period counter runs from 0 to PERIOD-1 and then returns to 0. One period is PERIOD clocks.
- R3: Both outputs are low while the count is less than or equal to the sampled dead length. Count 0 is always blanked, so a dead length of 0 still gives one clock of blanking. A pulse starts at count dead+1.
- R4: A pulse is high while dead < count < cmp. Its length is therefore max(0, min(cmp, PERIOD) − dead − 1) clocks, and a compare value at or below dead+1 gives no pulse.
- R5: At most one pulse per period. A pulse that ends early, for example through a fault, does not start again in the same period.
- R6: Successive pulses alternate between `out_a` and `out_b`.
- R7: The steering memory survives periods with no pulse. The next pulse still goes to the output that did not fire last.
- R8: If `ilim_trip` is high, `shdn_n` is low or `uvlo` is high, both outputs are low in that same cycle.
- R9: `cmp_val` and `dead_len` are sampled only on the clock edge that leaves count 0. A change during a period affects only the next period.
- R10: `out_a` and `out_b` are never high in the same cycle.
- R11: A high `sync_in` at a clock edge sets the count to 0 at that edge, which starts a new period. A pulse cut short by the restart counts as the pulse of the old period for steering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown, forces both outputs low |
| uvlo | input | 1 | Undervoltage lockout, high forces both outputs low |
| ilim_trip | input | 1 | Current-limit trip, high ends the pulse and forces outputs low |
| sync_in | input | 1 | Period restart strobe |
| cmp_val | input | CNT_W | Count at which the pulse ends |
| dead_len | input | CNT_W | Blanking length at the start of each period |
| out_a | output | 1 | Phase A drive |
| out_b | output | 1 | Phase B drive |

## Verification
The sweep covers every dead length from 0 to 4 and every compare value from 0 to PERIOD+1. It therefore hits the zero-duty edge at cmp = dead+1 and the clipping edge where cmp ≥ PERIOD. An off-by-one in the window would show up as pulses that are one clock too long or too short, or that start on the wrong count.

The fault runs end a pulse mid-way. A design with no metering latch would restart the pulse once the fault clears, and a design that fails to gate combinationally would let the fault cycle through. Periods with no pulse check that the steering memory does not toggle on idle periods. A sync restart in the middle of a pulse checks that the truncated pulse still counts for steering. A mid-period compare change checks that the pulse in progress keeps its length.

// File: rtl/pwm_pp_pkg.sv
package pwm_pp_pkg;

  // which output receives the next pulse
  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;

  // fault inputs normalised to active-high
  typedef struct packed {
    logic ilim;
    logic shdn;
    logic uvlo;
  } fault_t;

  function automatic logic any_fault(input fault_t f);
    return f.ilim | f.shdn | f.uvlo;
  endfunction

endpackage

// File: rtl/pwm_pp_timebase.sv
module pwm_pp_timebase #(
  parameter int CNT_W  = 8,
  parameter int PERIOD = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  output logic [CNT_W-1:0] cnt_q,
  output logic             period_start
);

  localparam int FULL = 1 << CNT_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic             at_last;
  logic [CNT_W-1:0] cnt_d;

  // a period spanning the whole counter range wraps on its own
  generate
    if (PERIOD == FULL) begin : g_natural_wrap
      assign at_last = 1'b0;
    end else begin : g_compare_wrap
      assign at_last = (cnt_q == LAST);
    end
  endgenerate

  always_comb begin
    if (sync_in || at_last) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign period_start = (cnt_q == '0);

endmodule

// File: rtl/pwm_pp_window.sv
module pwm_pp_window #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_start,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [CNT_W-1:0] dead_len,
  output logic             win
);

  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] dead_q;

  // settings are captured only while count 0 (always blanked) is present
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      dead_q <= '0;
    end else if (period_start) begin
      cmp_q  <= cmp_val;
      dead_q <= dead_len;
    end
  end

  // blanked through dead_q, pulse ends when count reaches cmp_q
  assign win = (cnt > dead_q) && (cnt < cmp_q);

endmodule

// File: rtl/pwm_pp_steer.sv
module pwm_pp_steer
  import pwm_pp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   period_start,
  input  logic   win,
  input  fault_t flt,
  output logic   out_a,
  output logic   out_b
);

  logic  active;
  logic  was_act_q;
  logic  lock_q;
  logic  pulse_end;
  side_e side_q;
  logic [1:0] drive;

  assign active    = win & ~any_fault(flt) & ~lock_q;
  assign pulse_end = was_act_q & ~active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_act_q <= 1'b0;
      lock_q    <= 1'b0;
      side_q    <= SIDE_A;
    end else begin
      was_act_q <= active;
      // metering latch: arm at period start, close when a pulse ends
      if (period_start) lock_q <= 1'b0;
      else if (pulse_end) lock_q <= 1'b1;
      // steering memory flips only when a real pulse finishes
      if (pulse_end) side_q <= (side_q == SIDE_A) ? SIDE_B : SIDE_A;
    end
  end

  generate
    for (genvar g = 0; g < 2; g++) begin : g_drive
      assign drive[g] = active & (side_q == side_e'(g));
    end
  endgenerate

  assign out_a = drive[0];
  assign out_b = drive[1];

endmodule

// File: rtl/pwm_pp_core.sv
module pwm_pp_core
  import pwm_pp_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PERIOD = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shdn_n,
  input  logic             uvlo,
  input  logic             ilim_trip,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [CNT_W-1:0] dead_len,
  output logic             out_a,
  output logic             out_b
);

  logic [CNT_W-1:0] cnt_q;
  logic             period_start;
  logic             win;
  fault_t           flt;

  assign flt.ilim = ilim_trip;
  assign flt.shdn = ~shdn_n;
  assign flt.uvlo = uvlo;

  pwm_pp_timebase #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_tb (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_in      (sync_in),
    .cnt_q        (cnt_q),
    .period_start (period_start)
  );

  pwm_pp_window #(.CNT_W(CNT_W)) u_win (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start),
    .cnt          (cnt_q),
    .cmp_val      (cmp_val),
    .dead_len     (dead_len),
    .win          (win)
  );

  pwm_pp_steer u_steer (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start),
    .win          (win),
    .flt          (flt),
    .out_a        (out_a),
    .out_b        (out_b)
  );

endmodule

// File: rtl/pwm_pp_chk.sv
module pwm_pp_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_a,
  input logic             out_b,
  input logic             ilim_trip,
  input logic             shdn_n,
  input logic             uvlo,
  input logic [CNT_W-1:0] cnt
);

  logic a_d, b_d, seen_q, have_last, last_a;
  logic act, rise_a, rise_b, rise_any;

  assign act      = out_a | out_b;
  assign rise_a   = out_a & ~a_d;
  assign rise_b   = out_b & ~b_d;
  assign rise_any = rise_a | rise_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_d <= 1'b0; b_d <= 1'b0; seen_q <= 1'b0;
      have_last <= 1'b0; last_a <= 1'b0;
    end else begin
      a_d <= out_a;
      b_d <= out_b;
      seen_q <= (cnt == '0) ? 1'b0 : (seen_q | act);
      if (rise_a) begin have_last <= 1'b1; last_a <= 1'b1; end
      else if (rise_b) begin have_last <= 1'b1; last_a <= 1'b0; end
    end
  end

  // R10
  never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && out_b));

  // R8
  fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_trip || !shdn_n || uvlo) |-> (!out_a && !out_b));

  // R3
  start_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (!out_a && !out_b));

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_any && seen_q && !(a_d || b_d)));

  // R6
  a_after_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_a && have_last) |-> !last_a);

  // R6 (and R1: first pulse on A)
  b_after_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_b |-> (have_last && last_a));

endmodule

bind pwm_pp_core pwm_pp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_a     (out_a),
  .out_b     (out_b),
  .ilim_trip (ilim_trip),
  .shdn_n    (shdn_n),
  .uvlo      (uvlo),
  .cnt       (cnt_q)
);

// File: tb/test_pwm_pp_core.sv
module test_pwm_pp_core;

  localparam int CNT_W = 8;
  localparam int P     = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shdn_n = 1'b1, uvlo = 1'b0, ilim_trip = 1'b0, sync_in = 1'b0;
  logic [CNT_W-1:0] cmp_val = '0, dead_len = '0;
  logic out_a, out_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwm_pp_core #(.CNT_W(CNT_W), .PERIOD(P)) i_pwm_pp_core (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .uvlo(uvlo),
    .ilim_trip(ilim_trip), .sync_in(sync_in), .cmp_val(cmp_val),
    .dead_len(dead_len), .out_a(out_a), .out_b(out_b)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // apply reset; R1: outputs low while held
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 out_a in reset", int'(out_a), 0);
    chk("R1 out_b in reset", int'(out_b), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // one period of P samples; events fire after the sample at their offset
  task automatic run_period(input int f_off, input int f_kind, input int s_off,
                            input int c_off, input int c_new,
                            output int na, output int nb, output int fa,
                            output int fb, output int imm_bad, output int both);
    na = 0; nb = 0; fa = -1; fb = -1; imm_bad = 0; both = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      ilim_trip = 1'b0; shdn_n = 1'b1; uvlo = 1'b0; sync_in = 1'b0;
      #1;
      if (out_a) begin na++; if (fa < 0) fa = i; end
      if (out_b) begin nb++; if (fb < 0) fb = i; end
      if (out_a && out_b) both++;
      if (i == c_off) cmp_val = CNT_W'(c_new);
      if (i == f_off) begin
        case (f_kind)
          0: ilim_trip = 1'b1;
          1: shdn_n = 1'b0;
          default: uvlo = 1'b1;
        endcase
        #1;
        if (out_a || out_b) imm_bad++;
      end
      if (i == s_off) begin
        sync_in = 1'b1;
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog R1..: run hung, actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int na, nb, fa, fb, ib, bo, len;

    // sweep of dead time and compare value: R2 R3 R4 R6 R10
    for (int d = 0; d <= 4; d++) begin
      for (int c = 0; c <= P + 1; c++) begin
        cmp_val = CNT_W'(c); dead_len = CNT_W'(d);
        do_reset();
        len = ((c < P) ? c : P) - d - 1;
        if (len < 0) len = 0;
        for (int j = 0; j < 4; j++) begin
          run_period(-1, 0, -1, -1, 0, na, nb, fa, fb, ib, bo);
          chk($sformatf("R4 R6 len A d=%0d c=%0d p=%0d", d, c, j), na, (j % 2 == 0) ? len : 0);
          chk($sformatf("R4 R6 len B d=%0d c=%0d p=%0d", d, c, j), nb, (j % 2 == 1) ? len : 0);
          if (len > 0)
            chk($sformatf("R3 start d=%0d c=%0d", d, c), (j % 2 == 0) ? fa : fb, d + 1);
          chk("R10 overlap", bo, 0);
        end
      end
    end

    // faults end the pulse at once, no restart, then steering continues: R8 R5
    for (int k = 0; k < 3; k++) begin
      cmp_val = 8'd12; dead_len = 8'd2;
      do_reset();
      run_period(5, k, -1, -1, 0, na, nb, fa, fb, ib, bo);
      chk($sformatf("R8 immediate cut kind=%0d", k), ib, 0);
      chk($sformatf("R5 no restart A kind=%0d", k), na, 3);
      run_period(-1, 0, -1, -1, 0, na, nb, fa, fb, ib, bo);
      chk($sformatf("R6 after fault B kind=%0d", k), nb, 9);
      chk($sformatf("R6 after fault A kind=%0d", k), na, 0);
    end

    // steering memory across empty periods: R7
    cmp_val = 8'd12; dead_len = 8'd2;
    do_reset();
    run_period(-1, 0, -1, 4, 0, na, nb, fa, fb, ib, bo);
    chk("R7 first A", na, 9);
    run_period(-1, 0, -1, -1, 0, na, nb, fa, fb, ib, bo);
    chk("R7 empty period 1", na + nb, 0);
    run_period(-1, 0, -1, 4, 12, na, nb, fa, fb, ib, bo);
    chk("R7 empty period 2", na + nb, 0);
    run_period(-1, 0, -1, -1, 0, na, nb, fa, fb, ib, bo);
    chk("R7 resumes on B", nb, 9);
    chk("R7 A idle", na, 0);

    // compare changed mid-period: R9
    cmp_val = 8'd12; dead_len = 8'd2;
    do_reset();
    run_period(-1, 0, -1, 4, 6, na, nb, fa, fb, ib, bo);
    chk("R9 current pulse kept", na, 9);
    run_period(-1, 0, -1, -1, 0, na, nb, fa, fb, ib, bo);
    chk("R9 new value next period", nb, 3);

    // sync restart during a pulse: R11
    cmp_val = 8'd12; dead_len = 8'd2;
    do_reset();
    run_period(-1, 0, 7, -1, 0, na, nb, fa, fb, ib, bo);
    chk("R11 truncated A", na, 5);
    run_period(-1, 0, -1, -1, 0, na, nb, fa, fb, ib, bo);
    chk("R11 restart pulse on B", nb, 9);
    chk("R11 restart pulse start", fb, 3);
    // sync inside blanking: nothing fired, steering unchanged
    run_period(-1, 0, 1, -1, 0, na, nb, fa, fb, ib, bo);
    chk("R11 blank sync no pulse", na + nb, 0);
    run_period(-1, 0, -1, -1, 0, na, nb, fa, fb, ib, bo);
    chk("R11 after blank sync A", na, 9);

    // reset clears steering memory: R1
    cmp_val = 8'd12; dead_len = 8'd2;
    do_reset();
    run_period(-1, 0, -1, -1, 0, na, nb, fa, fb, ib, bo);
    chk("R1 first pulse A", na, 9);
    do_reset();
    run_period(-1, 0, -1, -1, 0, na, nb, fa, fb, ib, bo);
    chk("R1 again on A", na, 9);
    chk("R1 B idle", nb, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule